// File: doc/BRIEF.md
# I2C Bus-Clear Pulse Generator

This block frees an I2C bus after a target device has been left mid-byte and keeps SDA pulled low. When software raises a one-cycle clear request, the block latches the 4-bit pulse-count field. It then clocks SCL low and high that many times through an open-drain enable while SDA stays released. A stuck target normally finishes shifting its byte and its acknowledge bit within nine clocks and then lets SDA go. For this reason a count larger than nine is cut down to nine.

Both bus lines are brought into the clock domain through a synchronizer chain. They are exposed as a two-bit monitor word: SDA in bit 0 and SCL in bit 1, with 1 meaning the line is high. A separate flag is set when both lines are high. Software can use this to retry one pulse at a time until SDA reads high. SDA passes through a glitch filter that rejects short spikes at the cost of extra delay. A bypass input skips the filter. A unit-reset input holds the pulse engine idle for as long as it is asserted.

Top module: `bus_unstick`

## Requirements
- R1: After reset, `busy`, `scl_oe` and `sda_oe` are all 0.
- R2: A request with count n from 1 to 9 produces exactly n SCL pulses. A pulse is `scl_oe`=1 for HALF_CYC cycles followed by `scl_oe`=0 for HALF_CYC cycles. The first low phase starts in the cycle after the clock edge that samples the request.
- R3: A count field value from 10 to 15 produces exactly 9 pulses.
- R4: A count of 0 produces no pulse, and `busy` stays 0.
- R5: `busy` is 1 from the cycle after the request for exactly 2·HALF_CYC·n cycles. `scl_oe` is never 1 while `busy` is 0.
- R6: `sda_oe` is 0 at all times, so SDA is never driven.
- R7: A request that arrives while `busy` is 1 is ignored. The pulse count and the busy length of the running sequence do not change.
- R8: While `unit_rst` is 1, `busy` and `scl_oe` are 0 from the next cycle, and requests are ignored.
- R9: `line_mon[0]` is the SDA level and `line_mon[1]` is the SCL level. With `filt_bypass`=1, a line change is visible on `line_mon` three cycles after it (two synchronizer stages plus the output register).
- R10: With `filt_bypass`=0, an SDA change reaches `line_mon[0]` FILT_LEN cycles later than with the bypass. An SDA level lasting fewer than FILT_LEN cycles does not reach `line_mon[0]`.
- R11: `bus_free` is 1 exactly when both monitor bits are 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_rst | input | 1 | Holds the pulse engine idle while 1 |
| clr_req | input | 1 | One-cycle bus-clear request |
| pulse_cnt | input | CNT_W | Number of SCL pulses requested |
| filt_bypass | input | 1 | 1 skips the SDA glitch filter |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low (always 0) |
| busy | output | 1 | Pulse sequence in progress |
| line_mon | output | 2 | Bit 0 SDA level, bit 1 SCL level |
| bus_free | output | 1 | Both lines read high |

## Verification
Corrupting the phase counter or the remaining-pulse counter shows up on `scl_oe` within one half period. The visible symptoms are a low or high phase of the wrong length, an extra or missing pulse, or `busy` ending early or late. If the engine fails to leave its idle state, the error appears at the first request: no pulse appears, or `busy` rises on a zero count. A fault in the monitor path shows as a wrong bit on `line_mon` or a wrong delay. The synchronizer, register and filter delays fix the exact cycle of every change, so the error appears within three plus FILT_LEN cycles of a line change.

// File: rtl/bclr_pkg.sv
package bclr_pkg;
  localparam int unsigned BCLR_MAX_PULSES = 9;

  function automatic int unsigned bclr_clamp(input int unsigned req_n, input int unsigned limit);
    return (req_n > limit) ? limit : req_n;
  endfunction
endpackage

// File: rtl/bclr_sync.sv
module bclr_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/bclr_filter.sv
module bclr_filter #(
  parameter int unsigned LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b1;
      run  <= '0;
    end else if (din == dout) begin
      run <= '0;
    end else if (run == CW'(LEN-1)) begin
      dout <= din;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end
endmodule

// File: rtl/bclr_engine.sv
module bclr_engine #(
  parameter int unsigned HALF_CYC   = 4,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             busy,
  output logic             scl_low
);
  import bclr_pkg::*;
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);

  logic [HW-1:0] phase_t;
  logic [PW-1:0] left;
  logic [PW-1:0] n_eff;

  always_comb n_eff = PW'(bclr_clamp(int'(count), MAX_PULSES));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy    <= 1'b0;
      scl_low <= 1'b0;
      phase_t <= '0;
      left    <= '0;
    end else if (!busy) begin
      if (start && n_eff != '0) begin
        busy    <= 1'b1;
        scl_low <= 1'b1;
        phase_t <= '0;
        left    <= n_eff;
      end
    end else if (phase_t == HW'(HALF_CYC - 1)) begin
      phase_t <= '0;
      if (scl_low) begin
        scl_low <= 1'b0;
      end else if (left == PW'(1)) begin
        busy <= 1'b0;
      end else begin
        left    <= left - 1'b1;
        scl_low <= 1'b1;
      end
    end else begin
      phase_t <= phase_t + 1'b1;
    end
  end
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick #(
  parameter int unsigned HALF_CYC    = 4,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unit_rst,
  input  logic             clr_req,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic             filt_bypass,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             busy,
  output logic [1:0]       line_mon,
  output logic             bus_free
);
  import bclr_pkg::*;

  logic [1:0] synced;
  logic       sda_filt;
  logic       sda_pick;

  bclr_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(synced)
  );

  bclr_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din(synced[0]), .dout(sda_filt)
  );

  bclr_engine #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W), .MAX_PULSES(BCLR_MAX_PULSES)) u_eng (
    .clk(clk), .rst(rst), .hold(unit_rst), .start(clr_req), .count(pulse_cnt),
    .busy(busy), .scl_low(scl_oe)
  );

  assign sda_pick = filt_bypass ? synced[0] : sda_filt;
  assign sda_oe   = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_mon <= 2'b11;
      bus_free <= 1'b1;
    end else begin
      line_mon <= {synced[1], sda_pick};
      bus_free <= synced[1] & sda_pick;
    end
  end
endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             unit_rst,
  input logic             clr_req,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             busy,
  input logic [1:0]       line_mon,
  input logic             bus_free
);
  logic       prev_oe;
  logic [7:0] rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_oe <= 1'b0;
      rises   <= '0;
    end else begin
      prev_oe <= scl_oe;
      if (!busy) rises <= '0;
      else if (scl_oe && !prev_oe) rises <= rises + 1'b1;
    end
  end

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (rst) rises <= 8'd9); // R3
  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst) scl_oe |-> busy); // R5
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(clr_req) && $past(pulse_cnt) != '0 && !$past(unit_rst))); // R2
  AST_ZERO_NOP: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !busy && pulse_cnt == '0) |=> !busy); // R4
  AST_URST_HOLD: assert property (@(posedge clk) disable iff (rst)
    unit_rst |=> (!busy && !scl_oe)); // R8
  AST_SDA_FREE: assert property (@(posedge clk) disable iff (rst) !sda_oe); // R6
  AST_FREE_FLAG: assert property (@(posedge clk) disable iff (rst)
    bus_free == (line_mon == 2'b11)); // R11
endmodule

bind bus_unstick bus_unstick_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .unit_rst(unit_rst), .clr_req(clr_req), .pulse_cnt(pulse_cnt),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .line_mon(line_mon), .bus_free(bus_free)
);

// File: tb/bus_unstick_test.sv
module bus_unstick_test;
  localparam int H = 3;
  localparam int F = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic unit_rst = 1'b0;
  logic clr_req = 1'b0;
  logic [3:0] pulse_cnt = '0;
  logic filt_bypass = 1'b1;
  logic scl_ext = 1'b1;
  logic sda_ext = 1'b1;
  logic scl_oe, sda_oe, busy, bus_free;
  logic [1:0] line_mon;
  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bus_unstick #(.HALF_CYC(H), .CNT_W(4), .SYNC_STAGES(2), .FILT_LEN(F)) uut (
    .clk(clk), .rst(rst), .unit_rst(unit_rst), .clr_req(clr_req), .pulse_cnt(pulse_cnt),
    .filt_bypass(filt_bypass), .scl_in(scl_oe ? 1'b0 : scl_ext), .sda_in(sda_ext),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .line_mon(line_mon), .bus_free(bus_free)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issues a request and measures the sequence; inject_at>0 pulses a second request mid-run.
  task automatic run_seq(input int n, input int inject_at, input string tag);
    int exp_n, busy_cyc, rises, low_run, bad_low, oe_idle, sda_hit;
    logic prev;
    exp_n = (n > 9) ? 9 : n;
    busy_cyc = 0; rises = 0; low_run = 0; bad_low = 0; oe_idle = 0; sda_hit = 0;
    prev = 1'b0;
    @(negedge clk); clr_req = 1'b1; pulse_cnt = 4'(n);
    @(negedge clk); clr_req = 1'b0;
    check({tag, " first phase"}, int'(scl_oe), exp_n > 0 ? 1 : 0);
    for (int k = 0; k < 80; k++) begin
      if (k == inject_at && inject_at > 0) begin clr_req = 1'b1; pulse_cnt = 4'd9; end
      else clr_req = 1'b0;
      busy_cyc += int'(busy);
      if (scl_oe && !prev) rises++;
      if (scl_oe) low_run++;
      else begin
        if (prev && low_run != H) bad_low++;
        low_run = 0;
      end
      if (scl_oe && !busy) oe_idle++;
      if (sda_oe) sda_hit++;
      prev = scl_oe;
      @(negedge clk);
    end
    clr_req = 1'b0;
    check({tag, " pulse count"}, rises, exp_n);
    check({tag, " busy length R5"}, busy_cyc, 2 * H * exp_n);
    check({tag, " low phase length R2"}, bad_low, 0);
    check({tag, " scl_oe outside busy R5"}, oe_idle, 0);
    check({tag, " sda never driven R6"}, sda_hit, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R11 free at rest", int'(bus_free), 1);

    // R2 R3 R4 sweep over every count value
    for (int n = 0; n < 16; n++) begin
      if (n == 0) run_seq(n, 0, "R4 zero");
      else if (n <= 9) run_seq(n, 0, "R2 count");
      else run_seq(n, 0, "R3 clamp");
    end

    // R7 request while busy
    run_seq(5, 4, "R7 busy ignore");
    run_seq(2, 7, "R7 late ignore");

    // R8 unit reset mid-sequence
    @(negedge clk); clr_req = 1'b1; pulse_cnt = 4'd9;
    @(negedge clk); clr_req = 1'b0;
    repeat (5) @(negedge clk);
    unit_rst = 1'b1;
    @(negedge clk);
    check("R8 busy cleared", int'(busy), 0);
    check("R8 scl released", int'(scl_oe), 0);
    clr_req = 1'b1; pulse_cnt = 4'd4;
    @(negedge clk); clr_req = 1'b0;
    check("R8 request ignored", int'(busy), 0);
    @(negedge clk); unit_rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 stays idle after release", int'(busy), 0);
    run_seq(3, 0, "R8 works after release");

    // R9 monitor with bypass
    filt_bypass = 1'b1;
    repeat (6) @(negedge clk);
    sda_ext = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 sda not yet", int'(line_mon[0]), 1);
    @(negedge clk);
    check("R9 sda bit0 low", int'(line_mon[0]), 0);
    check("R11 free drops", int'(bus_free), 0);
    check("R9 scl bit1 high", int'(line_mon[1]), 1);
    sda_ext = 1'b1;
    scl_ext = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 scl not yet", int'(line_mon[1]), 1);
    @(negedge clk);
    check("R9 scl bit1 low", int'(line_mon[1]), 0);
    check("R9 sda back high", int'(line_mon[0]), 1);
    check("R11 free with scl low", int'(bus_free), 0);
    scl_ext = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 free restored", int'(bus_free), 1);

    // R10 filter delay and glitch rejection
    filt_bypass = 1'b0;
    repeat (8) @(negedge clk);
    sda_ext = 1'b0;
    repeat (2 + F) @(negedge clk);
    check("R10 filtered not yet", int'(line_mon[0]), 1);
    @(negedge clk);
    check("R10 filtered arrives", int'(line_mon[0]), 0);
    sda_ext = 1'b1;
    repeat (12) @(negedge clk);
    check("R10 filtered high again", int'(line_mon[0]), 1);
    begin
      int seen_low;
      seen_low = 0;
      sda_ext = 1'b0;
      repeat (F - 1) @(negedge clk);
      sda_ext = 1'b1;
      for (int k = 0; k < 12; k++) begin
        if (!line_mon[0]) seen_low++;
        @(negedge clk);
      end
      check("R10 glitch rejected", seen_low, 0);
      filt_bypass = 1'b1;
      seen_low = 0;
      sda_ext = 1'b0;
      repeat (F - 1) @(negedge clk);
      sda_ext = 1'b1;
      for (int k = 0; k < 12; k++) begin
        if (!line_mon[0]) seen_low++;
        @(negedge clk);
      end
      check("R9 bypass passes short pulse", seen_low, F - 1);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule